// File: doc/BRIEF.md
# Staggered Output Turn-On Sequencer

This block gates a bank of LED sink outputs, arranged as eight channel positions with a red, a green and a blue output at each position. Its purpose is to spread the moment those outputs switch on, which limits the inrush current drawn when a whole panel lights at once. Each output carries a latched data bit. An output conducts only when three things hold: the active-low output enable is asserted, its data bit is 1, and its channel position has been released.

In staggered mode the first position is released as soon as the enable falls. Each later position follows one fixed step after the one before it, so the eighth position waits seven steps. The step length is a parameter counted in clock cycles. The three colours at one position are always released together. A mode input selects bypass instead, and in bypass every output follows the enable directly with no added delay. Deasserting the enable switches every output off at once, with no staggering, and restarts the sequence.

Top module: `stagger_on_seq`

## Requirements
- R1: While `rstN` is low, the step count is held at zero, so with `enN` low and bypass off only position 1 (bit 0) of each colour can be on.
- R2: Whenever `enN` is high, every bit of `redOn`, `grnOn` and `bluOn` is 0 in that same cycle, whatever the data and the mode.
- R3: When `bypass` is 1 and `enN` is low, each colour output equals its data input in the same cycle.
- R4: With `bypass` 0, position 1 (bit 0) follows its data bit in the same cycle that `enN` falls, with no delay.
- R5: With `bypass` 0, the position at bit index p (1 to 7) is released after exactly p·STEP_TICKS rising clock edges at which `enN` was sampled low, counted from the fall of `enN`.
- R6: The red, green and blue outputs of one position are released in the same cycle.
- R7: An output whose data bit is 0 stays off, even after its position has been released.
- R8: A rise of `enN` that lasts for at least one rising clock edge clears the sequence, so the next fall starts again from position 1 only.
- R9: Once the last position (bit 7) has been released, after 7·STEP_TICKS edges, all positions stay released for as long as `enN` stays low.
- R10: Bit i of every data and output vector belongs to channel position i+1, and the release order runs from bit 0 up to bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that times the release steps |
| rstN | input | 1 | Active-low synchronous reset |
| enN | input | 1 | Active-low output enable |
| bypass | input | 1 | 1 = no staggering; 0 = staggered release |
| redData | input | NUM_POS | Latched data for the red outputs |
| grnData | input | NUM_POS | Latched data for the green outputs |
| bluData | input | NUM_POS | Latched data for the blue outputs |
| redOn | output | NUM_POS | Red output drive, 1 = sinking current |
| grnOn | output | NUM_POS | Green output drive, 1 = sinking current |
| bluOn | output | NUM_POS | Blue output drive, 1 = sinking current |

## Verification
The assertions assume that `enN` and `bypass` are synchronous to `clk` and hold steady for whole cycles, so that each level is seen by at least one rising edge. The property that released outputs never drop away also assumes the data and the mode stay constant while the enable is held low, and it checks only the cycles where that is true. The bench changes every input at the falling clock edge and keeps the data and mode fixed through each enable-low window. It raises `enN` for whole cycles whenever it wants to restart the sequence.

// File: rtl/stagger_pkg.sv
package stagger_pkg;
  // Strobes from the tick control to the release datapath
  typedef struct packed {
    logic clear;    // enable deasserted: restart at position 1
    logic advance;  // one step length elapsed with enable asserted
  } stepStrobe_t;
endpackage

// File: rtl/stagger_ctrl.sv
module stagger_ctrl
  import stagger_pkg::*;
#(
  parameter int STEP_TICKS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enN,
  output stepStrobe_t strobe
);
  localparam int TICK_W = $clog2(STEP_TICKS + 1);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(STEP_TICKS - 1);

  logic [TICK_W-1:0] tickCnt;
  logic stepDone;

  assign stepDone = (tickCnt == LAST_TICK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (enN || stepDone) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.clear   = enN;
    strobe.advance = !enN && stepDone;
  end
endmodule

// File: rtl/stagger_dp.sv
module stagger_dp
  import stagger_pkg::*;
#(
  parameter int NUM_POS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  stepStrobe_t        strobe,
  input  logic               enN,
  input  logic               bypass,
  input  logic [NUM_POS-1:0] redData,
  input  logic [NUM_POS-1:0] grnData,
  input  logic [NUM_POS-1:0] bluData,
  output logic [NUM_POS-1:0] redOn,
  output logic [NUM_POS-1:0] grnOn,
  output logic [NUM_POS-1:0] bluOn
);
  localparam int POS_W = (NUM_POS > 1) ? $clog2(NUM_POS) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_POS - 1);

  logic [POS_W-1:0]   stepCnt;
  logic [NUM_POS-1:0] releaseMask;
  logic [NUM_POS-1:0] gate;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      stepCnt <= '0;
    end else if (strobe.advance && (stepCnt != LAST_POS)) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  // Thermometer release: position p opens once p steps have elapsed
  for (genvar p = 0; p < NUM_POS; p++) begin : gPos
    if (p == 0) begin : gFirst
      assign releaseMask[p] = 1'b1;
    end else begin : gLater
      assign releaseMask[p] = bypass || (stepCnt >= POS_W'(p));
    end
    assign gate[p]  = releaseMask[p] && !enN;
    assign redOn[p] = gate[p] && redData[p];
    assign grnOn[p] = gate[p] && grnData[p];
    assign bluOn[p] = gate[p] && bluData[p];
  end
endmodule

// File: rtl/stagger_on_seq.sv
module stagger_on_seq
  import stagger_pkg::*;
#(
  parameter int NUM_POS    = 8,
  parameter int STEP_TICKS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enN,
  input  logic               bypass,
  input  logic [NUM_POS-1:0] redData,
  input  logic [NUM_POS-1:0] grnData,
  input  logic [NUM_POS-1:0] bluData,
  output logic [NUM_POS-1:0] redOn,
  output logic [NUM_POS-1:0] grnOn,
  output logic [NUM_POS-1:0] bluOn
);
  stepStrobe_t strobe;

  stagger_ctrl #(.STEP_TICKS(STEP_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .enN(enN), .strobe(strobe)
  );

  stagger_dp #(.NUM_POS(NUM_POS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .enN(enN), .bypass(bypass),
    .redData(redData), .grnData(grnData), .bluData(bluData),
    .redOn(redOn), .grnOn(grnOn), .bluOn(bluOn)
  );
endmodule

// File: rtl/stagger_on_seq_chk.sv
module stagger_on_seq_chk #(
  parameter int NUM_POS = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               enN,
  input logic               bypass,
  input logic [NUM_POS-1:0] redData,
  input logic [NUM_POS-1:0] grnData,
  input logic [NUM_POS-1:0] bluData,
  input logic [NUM_POS-1:0] redOn,
  input logic [NUM_POS-1:0] grnOn,
  input logic [NUM_POS-1:0] bluOn
);
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    enN |-> (redOn == '0 && grnOn == '0 && bluOn == '0)); // R2

  AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (bypass && !enN) |-> (redOn == redData && grnOn == grnData && bluOn == bluData)); // R3

  AST_FIRST_NO_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    !enN |-> (redOn[0] == redData[0] && grnOn[0] == grnData[0] && bluOn[0] == bluData[0])); // R4

  AST_COLOURS_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    ((redOn & grnData) == (grnOn & redData)) && ((redOn & bluData) == (bluOn & redData))); // R6

  AST_DATA_GATES: assert property (@(posedge clk) disable iff (!rstN)
    ((redOn & ~redData) == '0) && ((grnOn & ~grnData) == '0) && ((bluOn & ~bluData) == '0)); // R7

  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    !bypass |-> (((redOn >> 1) & redData & ~redOn) == '0)); // R10

  AST_NO_RETRACT: assert property (@(posedge clk) disable iff (!rstN)
    (!enN && $past(!enN) && !bypass && $past(!bypass) &&
     $stable(redData) && $past(rstN)) |-> ((redOn & $past(redOn)) == $past(redOn))); // R9
endmodule

bind stagger_on_seq stagger_on_seq_chk #(.NUM_POS(NUM_POS)) uChk (
  .clk(clk), .rstN(rstN), .enN(enN), .bypass(bypass),
  .redData(redData), .grnData(grnData), .bluData(bluData),
  .redOn(redOn), .grnOn(grnOn), .bluOn(bluOn)
);

// File: tb/tb_stagger_on_seq.sv
`timescale 1ns/1ps
module tb_stagger_on_seq;
  localparam int NP   = 8;
  localparam int STEP = 4;
  localparam int NV   = 6;
  // {bypass, red, green, blue}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'hFF, 8'hFF, 8'hFF},
    {1'b0, 8'hA5, 8'h5A, 8'h3C},
    {1'b1, 8'hFF, 8'h0F, 8'hF0},
    {1'b0, 8'h81, 8'h42, 8'h24},
    {1'b1, 8'h96, 8'h69, 8'hC3},
    {1'b0, 8'hFE, 8'h7F, 8'h18}
  };

  logic clk = 1'b0;
  logic rstN, enN, bypass;
  logic [NP-1:0] redData, grnData, bluData, redOn, grnOn, bluOn;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  stagger_on_seq #(.NUM_POS(NP), .STEP_TICKS(STEP)) dut (
    .clk(clk), .rstN(rstN), .enN(enN), .bypass(bypass),
    .redData(redData), .grnData(grnData), .bluData(bluData),
    .redOn(redOn), .grnOn(grnOn), .bluOn(bluOn)
  );

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NP-1:0] expMask(input int k, input logic byp);
    logic [NP-1:0] m;
    for (int p = 0; p < NP; p++) m[p] = byp || (p <= k / STEP);
    return m;
  endfunction

  task automatic allOff(input string tag);
    chk({tag, " red"}, redOn, '0);
    chk({tag, " green"}, grnOn, '0);
    chk({tag, " blue"}, bluOn, '0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; enN = 1'b0; bypass = 1'b0;
    redData = '1; grnData = '1; bluData = '1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 red", redOn, 8'h01);
    chk("R1 green", grnOn, 8'h01);
    chk("R1 blue", bluOn, 8'h01);
    @(negedge clk);
    rstN = 1'b1; enN = 1'b1;
    #1 allOff("R2");

    // Table walk over data patterns and modes
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {bypass, redData, grnData, bluData} = VEC[i];
      enN = 1'b1;
      repeat (2) @(negedge clk);
      #1 allOff("R2");
      @(negedge clk);
      enN = 1'b0;
      for (int k = 0; k <= NP * STEP + 3; k++) begin
        string tag;
        if (k > 0) @(negedge clk);
        #1;
        tag = bypass ? "R3" : (k == 0) ? "R4" : (k >= (NP - 1) * STEP) ? "R9" : "R5";
        chk({tag, " red"}, redOn, redData & expMask(k, bypass));
        chk("R6 green", grnOn, grnData & expMask(k, bypass));
        chk("R6 blue", bluOn, bluData & expMask(k, bypass));
      end
      @(negedge clk);
      enN = 1'b1;
      #1 allOff("R2");
    end

    // Restart after a short enable-high gap
    @(negedge clk);
    bypass = 1'b0; redData = '1; grnData = '1; bluData = '1; enN = 1'b0;
    repeat (10) @(negedge clk);
    enN = 1'b1;
    #1 allOff("R2");
    @(negedge clk);
    enN = 1'b0;
    #1 chk("R8 restart", redOn, 8'h01);
    repeat (STEP) @(negedge clk);
    #1 chk("R8 second step", redOn, 8'h03);

    // Zero data stays off after full release
    @(negedge clk);
    redData = 8'h00;
    repeat (NP * STEP) @(negedge clk);
    #1 chk("R7 zero data", redOn, 8'h00);
    chk("R9 saturated green", grnOn, 8'hFF);

    // Last position alone lights only after seven steps
    @(negedge clk);
    enN = 1'b1; redData = 8'h80;
    @(negedge clk);
    enN = 1'b0;
    repeat ((NP - 1) * STEP - 1) @(negedge clk);
    #1 chk("R10 before last step", redOn, 8'h00);
    @(negedge clk);
    #1 chk("R10 last position", redOn, 8'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule